// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block walks switchable logic domains through a fixed power-up or power-down order, one domain at a time. A host raises a one-cycle request that names a domain index and the target state (on or off). While the block works through the steps it holds `busy` high. It pulses `done` when the target state is reached. Each domain presents plain control outputs to the power-switch fabric outside the block: a clock enable, a reset, a timer-load flag, a timer-run flag, a set of footer switch enables and an isolation-release flag.

Power-up follows a fixed order. The clock comes on first while the domain stays in reset. The timer is then loaded with its setup value, and the footers close one at a time. Next the timer starts and reset is released, and isolation is released last. Power-down runs the other way: isolation is restored first, then the timer stops, reset is asserted, the clock stops and all footers open together. Each step is held for a parameterised number of cycles so that the switches can settle. A combinational read port shows every domain's three control words at fixed byte offsets.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset every domain has clock enable 0, reset 1, timer load 0, timer run 0, all footers 0 and isolation release 0, and `busy`, `done` and `err` are all 0.
- R2: `rd_data` returns domain d's words at byte address 12*d + offset. Offset 0 is the timer word: bits GATE_W-1..1 are all ones when loaded, and bit 0 is run. Offset 4 is the control word: bit 1 is clock enable and bit 0 is reset. Offset 8 is the switch word: bits NUM_FOOTERS-1..0 are the footers and bit NUM_FOOTERS is isolation release. Any other address reads 0.
- R3: Power-up applies these steps in order: control word 3, timer word 0x01FFFFFE, switch word 0x01, 0x03, 0x07 and 0x0F, timer word 0x01FFFFFF, control word 2, and switch word 0x1F.
- R4: Power-down applies these steps in order: switch word 0x0F, timer word 0, control word 3, control word 1, and switch word 0.
- R5: A request accepted at clock edge E applies step k at edge E+1+k*STEP_CYCLES. `busy` is high for exactly n*STEP_CYCLES cycles, where n is 9 for power-up and 5 for power-down.
- R6: `done` is high for exactly one cycle, on the cycle in which `busy` falls, and is never high together with `busy`.
- R7: A request made while `busy` is high has no effect on any domain and sets `err`. `err` then stays high until reset.
- R8: A request for a domain that is already in the requested state raises `done` on the next cycle, leaves `busy` low and changes no output.
- R9: A request with a domain index of NUM_DOM or higher changes no domain and sets `err`. `busy` and `done` stay low.
- R10: In any cycle, at most one domain's outputs change, and only the requested domain's outputs change.
- R11: At all times, a stopped clock implies reset is asserted. Released isolation implies all footers closed, timer running and reset released. The footers always form a contiguous run from footer 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_dom | input | IDX_W | Domain index of the request |
| req_on | input | 1 | 1 = power up, 0 = power down |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky flag for a rejected request |
| rd_addr | input | ADDR_W | Byte address for readback |
| rd_data | output | 32 | Readback word |
| dom_clk_en | output | NUM_DOM | Clock enable per domain |
| dom_rst | output | NUM_DOM | Reset per domain |
| dom_timer_load | output | NUM_DOM | Timer setup loaded per domain |
| dom_timer_run | output | NUM_DOM | Timer running per domain |
| dom_footer | output | NUM_DOM*NUM_FOOTERS | Footer enables, domain d at bits d*NUM_FOOTERS upward |
| dom_iso_rel | output | NUM_DOM | Isolation release per domain |

## Verification
The hardest condition to reach from the ports is a second request that arrives while another domain is in the middle of its sequence. Rejecting it must leave both the active domain and the named domain untouched. The stimulus starts one domain's power-up, waits a few step periods, then fires a request for a different, idle domain. The bench then reads back both domains once the first sequence ends. Out-of-range indices and repeat requests for a domain that is already in the requested state are driven between full sequences. A reset in the middle of the run clears the sticky flag so that each error cause is seen on its own.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

   localparam int DOM_STRIDE = 12;
   localparam int OFF_TIMER  = 0;
   localparam int OFF_CTRL   = 4;
   localparam int OFF_SWITCH = 8;
   localparam int DN_STEPS   = 5;

   // one sequence step: which word is written and with what
   typedef struct packed {
      logic       wr_ctrl;
      logic       clk_on;
      logic       rst_on;
      logic       wr_timer;
      logic       t_load;
      logic       t_run;
      logic       wr_sw;
      logic [3:0] foot_cnt;
      logic       iso_rel;
      logic       mark_on;
      logic       mark_off;
   } step_act_t;

   function automatic step_act_t step_decode(input logic up, input logic [7:0] step,
                                             input int nfoot);
      step_act_t a;
      int        s;
      a = '0;
      s = int'(step);
      if (up) begin
         if (s == 0) begin
            a.wr_ctrl = 1'b1; a.clk_on = 1'b1; a.rst_on = 1'b1;
         end else if (s == 1) begin
            a.wr_timer = 1'b1; a.t_load = 1'b1;
         end else if (s <= nfoot + 1) begin
            a.wr_sw = 1'b1; a.foot_cnt = 4'(s - 1);
         end else if (s == nfoot + 2) begin
            a.wr_timer = 1'b1; a.t_load = 1'b1; a.t_run = 1'b1;
         end else if (s == nfoot + 3) begin
            a.wr_ctrl = 1'b1; a.clk_on = 1'b1;
         end else begin
            a.wr_sw = 1'b1; a.foot_cnt = 4'(nfoot); a.iso_rel = 1'b1; a.mark_on = 1'b1;
         end
      end else begin
         case (s)
            0: begin a.wr_sw = 1'b1; a.foot_cnt = 4'(nfoot); end
            1: begin a.wr_timer = 1'b1; end
            2: begin a.wr_ctrl = 1'b1; a.clk_on = 1'b1; a.rst_on = 1'b1; end
            3: begin a.wr_ctrl = 1'b1; a.rst_on = 1'b1; end
            default: begin a.wr_sw = 1'b1; a.mark_off = 1'b1; end
         endcase
      end
      return a;
   endfunction

endpackage

// File: rtl/pgs_ctrl.sv
module pgs_ctrl #(
   parameter int NUM_DOM     = 3,
   parameter int IDX_W       = 2,
   parameter int STEP_CYCLES = 4,
   parameter int UP_STEPS    = 9,
   parameter int DN_STEPS    = 5,
   parameter int STEP_W      = 4,
   parameter int CNT_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [IDX_W-1:0]  req_dom,
   input  logic              req_on,
   input  logic [NUM_DOM-1:0] dom_on,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [IDX_W-1:0]  cur_dom,
   output logic              cur_up,
   output logic [STEP_W-1:0] step,
   output logic              step_fire
);

   localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(STEP_CYCLES - 1);
   localparam logic [STEP_W-1:0] UP_LAST  = STEP_W'(UP_STEPS - 1);
   localparam logic [STEP_W-1:0] DN_LAST  = STEP_W'(DN_STEPS - 1);

   logic [CNT_W-1:0]  hold_cnt;
   logic              idx_ok;
   logic              already;
   logic [STEP_W-1:0] last_step;

   always_comb begin
      idx_ok  = (32'(req_dom) < NUM_DOM);
      already = 1'b0;
      for (int d = 0; d < NUM_DOM; d++) begin
         if (IDX_W'(d) == req_dom) already = (dom_on[d] == req_on);
      end
      last_step = cur_up ? UP_LAST : DN_LAST;
   end

   assign step_fire = busy && (hold_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
         cur_dom  <= '0;
         cur_up   <= 1'b0;
         step     <= '0;
         hold_cnt <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (req_valid) begin
               if (!idx_ok) begin
                  err <= 1'b1;
               end else if (already) begin
                  done <= 1'b1;
               end else begin
                  busy     <= 1'b1;
                  cur_dom  <= req_dom;
                  cur_up   <= req_on;
                  step     <= '0;
                  hold_cnt <= '0;
               end
            end
         end else begin
            if (req_valid) err <= 1'b1;
            if (hold_cnt == CNT_LAST) begin
               if (step == last_step) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  step     <= step + 1'b1;
                  hold_cnt <= '0;
               end
            end else begin
               hold_cnt <= hold_cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pgs_dom_cell.sv
module pgs_dom_cell
   import pgs_pkg::*;
#(
   parameter int NUM_FOOTERS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sel,
   input  step_act_t              act,
   output logic                   clk_en,
   output logic                   rst_o,
   output logic                   t_load,
   output logic                   t_run,
   output logic [NUM_FOOTERS-1:0] footer,
   output logic                   iso_rel,
   output logic                   pwr_on
);

   logic [3:0] foot_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_en     <= 1'b0;
         rst_o      <= 1'b1;
         t_load     <= 1'b0;
         t_run      <= 1'b0;
         foot_cnt_q <= '0;
         iso_rel    <= 1'b0;
         pwr_on     <= 1'b0;
      end else if (sel) begin
         if (act.wr_ctrl) begin
            clk_en <= act.clk_on;
            rst_o  <= act.rst_on;
         end
         if (act.wr_timer) begin
            t_load <= act.t_load;
            t_run  <= act.t_run;
         end
         if (act.wr_sw) begin
            foot_cnt_q <= act.foot_cnt;
            iso_rel    <= act.iso_rel;
         end
         if (act.mark_on)  pwr_on <= 1'b1;
         if (act.mark_off) pwr_on <= 1'b0;
      end
   end

   // footers close as a thermometer from bit 0
   always_comb begin
      for (int i = 0; i < NUM_FOOTERS; i++) footer[i] = (i < int'(foot_cnt_q));
   end

endmodule

// File: rtl/pgs_readback.sv
module pgs_readback
   import pgs_pkg::*;
#(
   parameter int NUM_DOM     = 3,
   parameter int NUM_FOOTERS = 4,
   parameter int GATE_W      = 25,
   parameter int ADDR_W      = 6
) (
   input  logic [ADDR_W-1:0]              rd_addr,
   input  logic [NUM_DOM-1:0]             clk_en,
   input  logic [NUM_DOM-1:0]             rst_v,
   input  logic [NUM_DOM-1:0]             t_load,
   input  logic [NUM_DOM-1:0]             t_run,
   input  logic [NUM_DOM*NUM_FOOTERS-1:0] footer,
   input  logic [NUM_DOM-1:0]             iso_rel,
   output logic [31:0]                    rd_data
);

   logic [31:0] term [NUM_DOM];

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      localparam logic [ADDR_W-1:0] A_TIM = ADDR_W'(d * DOM_STRIDE + OFF_TIMER);
      localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(d * DOM_STRIDE + OFF_CTRL);
      localparam logic [ADDR_W-1:0] A_SW  = ADDR_W'(d * DOM_STRIDE + OFF_SWITCH);
      logic [31:0] w_tim, w_ctl, w_sw;
      always_comb begin
         w_tim = '0;
         for (int b = 1; b < GATE_W; b++) w_tim[b] = t_load[d];
         w_tim[0] = t_run[d];
         w_ctl = {30'b0, clk_en[d], rst_v[d]};
         w_sw  = '0;
         w_sw[NUM_FOOTERS-1:0] = footer[d*NUM_FOOTERS +: NUM_FOOTERS];
         w_sw[NUM_FOOTERS]     = iso_rel[d];
         if (rd_addr == A_TIM)      term[d] = w_tim;
         else if (rd_addr == A_CTL) term[d] = w_ctl;
         else if (rd_addr == A_SW)  term[d] = w_sw;
         else                       term[d] = '0;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int d = 0; d < NUM_DOM; d++) rd_data = rd_data | term[d];
   end

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
   import pgs_pkg::*;
#(
   parameter int NUM_DOM     = 3,
   parameter int NUM_FOOTERS = 4,
   parameter int STEP_CYCLES = 4,
   parameter int GATE_W      = 25,
   localparam int IDX_W      = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
   localparam int ADDR_W     = $clog2(NUM_DOM * 12)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           req_valid,
   input  logic [IDX_W-1:0]               req_dom,
   input  logic                           req_on,
   output logic                           busy,
   output logic                           done,
   output logic                           err,
   input  logic [ADDR_W-1:0]              rd_addr,
   output logic [31:0]                    rd_data,
   output logic [NUM_DOM-1:0]             dom_clk_en,
   output logic [NUM_DOM-1:0]             dom_rst,
   output logic [NUM_DOM-1:0]             dom_timer_load,
   output logic [NUM_DOM-1:0]             dom_timer_run,
   output logic [NUM_DOM*NUM_FOOTERS-1:0] dom_footer,
   output logic [NUM_DOM-1:0]             dom_iso_rel
);

   localparam int UP_STEPS = NUM_FOOTERS + 5;
   localparam int STEP_W   = $clog2(UP_STEPS);
   localparam int CNT_W    = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;

   if (NUM_DOM < 1 || NUM_FOOTERS < 1 || NUM_FOOTERS > 8 ||
       STEP_CYCLES < 1 || GATE_W < 2 || GATE_W > 32) begin : g_bad_cfg
      $error("pwr_domain_seq: parameter out of supported range");
   end

   logic [NUM_DOM-1:0] dom_on;
   logic [IDX_W-1:0]   cur_dom;
   logic               cur_up;
   logic [STEP_W-1:0]  step;
   logic               step_fire;
   step_act_t          act;

   pgs_ctrl #(
      .NUM_DOM(NUM_DOM), .IDX_W(IDX_W), .STEP_CYCLES(STEP_CYCLES),
      .UP_STEPS(UP_STEPS), .DN_STEPS(DN_STEPS), .STEP_W(STEP_W), .CNT_W(CNT_W)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dom(req_dom),
      .req_on(req_on), .dom_on(dom_on), .busy(busy), .done(done), .err(err),
      .cur_dom(cur_dom), .cur_up(cur_up), .step(step), .step_fire(step_fire)
   );

   always_comb act = step_decode(cur_up, 8'(step), NUM_FOOTERS);

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_cell
      logic sel_d;
      assign sel_d = step_fire && (cur_dom == IDX_W'(d));
      pgs_dom_cell #(.NUM_FOOTERS(NUM_FOOTERS)) cell_i (
         .clk(clk), .rst_n(rst_n), .sel(sel_d), .act(act),
         .clk_en(dom_clk_en[d]), .rst_o(dom_rst[d]),
         .t_load(dom_timer_load[d]), .t_run(dom_timer_run[d]),
         .footer(dom_footer[d*NUM_FOOTERS +: NUM_FOOTERS]),
         .iso_rel(dom_iso_rel[d]), .pwr_on(dom_on[d])
      );
   end

   pgs_readback #(
      .NUM_DOM(NUM_DOM), .NUM_FOOTERS(NUM_FOOTERS), .GATE_W(GATE_W), .ADDR_W(ADDR_W)
   ) rb_i (
      .rd_addr(rd_addr), .clk_en(dom_clk_en), .rst_v(dom_rst), .t_load(dom_timer_load),
      .t_run(dom_timer_run), .footer(dom_footer), .iso_rel(dom_iso_rel), .rd_data(rd_data)
   );

endmodule

// File: rtl/pwr_domain_seq_chk.sv
module pwr_domain_seq_chk #(
   parameter int NUM_DOM     = 3,
   parameter int NUM_FOOTERS = 4
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           req_valid,
   input logic                           busy,
   input logic                           done,
   input logic                           err,
   input logic [NUM_DOM-1:0]             dom_clk_en,
   input logic [NUM_DOM-1:0]             dom_rst,
   input logic [NUM_DOM-1:0]             dom_timer_run,
   input logic [NUM_DOM*NUM_FOOTERS-1:0] dom_footer,
   input logic [NUM_DOM-1:0]             dom_iso_rel
);

   logic [NUM_DOM-1:0]             prev_clk, prev_rst, prev_run, prev_iso;
   logic [NUM_DOM*NUM_FOOTERS-1:0] prev_foot;
   logic [NUM_DOM-1:0]             moved;

   always_ff @(posedge clk) begin
      prev_clk  <= dom_clk_en;
      prev_rst  <= dom_rst;
      prev_run  <= dom_timer_run;
      prev_iso  <= dom_iso_rel;
      prev_foot <= dom_footer;
   end

   always_comb begin
      for (int d = 0; d < NUM_DOM; d++) begin
         moved[d] = (prev_clk[d] != dom_clk_en[d]) || (prev_rst[d] != dom_rst[d]) ||
                    (prev_run[d] != dom_timer_run[d]) || (prev_iso[d] != dom_iso_rel[d]) ||
                    (prev_foot[d*NUM_FOOTERS +: NUM_FOOTERS] !=
                     dom_footer[d*NUM_FOOTERS +: NUM_FOOTERS]);
      end
   end

   assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   assert_busy_from_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   assert_one_domain_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(moved) <= 1);

   assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> (moved == '0));

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_inv
      logic [NUM_FOOTERS-1:0] f;
      assign f = dom_footer[d*NUM_FOOTERS +: NUM_FOOTERS];

      assert_clk_off_in_rst_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !dom_clk_en[d] |-> dom_rst[d]);

      assert_iso_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
         dom_iso_rel[d] |-> (dom_timer_run[d] && !dom_rst[d] && (&f)));

      assert_run_after_footers_R3: assert property (@(posedge clk) disable iff (!rst_n)
         dom_timer_run[d] |-> (&f));

      assert_footer_thermo_R11: assert property (@(posedge clk) disable iff (!rst_n)
         ((f + 1'b1) & f) == '0);
   end

endmodule

bind pwr_domain_seq pwr_domain_seq_chk #(.NUM_DOM(NUM_DOM), .NUM_FOOTERS(NUM_FOOTERS)) chk_i (.*);

// File: tb/pwr_domain_seq_tb_top.sv
`timescale 1ns/100ps
module pwr_domain_seq_tb_top;

   localparam int ND   = 3;
   localparam int NF   = 4;
   localparam int S    = 4;
   localparam int GSET = 32'h01FFFFFE;
   localparam int GRUN = 32'h01FFFFFF;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_dom = '0;
   logic       req_on = 1'b0;
   logic [5:0] rd_addr = '0;
   logic       busy, done, err;
   logic [31:0] rd_data;
   logic [ND-1:0] dom_clk_en, dom_rst, dom_timer_load, dom_timer_run, dom_iso_rel;
   logic [ND*NF-1:0] dom_footer;

   pwr_domain_seq #(.NUM_DOM(ND), .NUM_FOOTERS(NF), .STEP_CYCLES(S)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dom(req_dom), .req_on(req_on),
      .busy(busy), .done(done), .err(err), .rd_addr(rd_addr), .rd_data(rd_data),
      .dom_clk_en(dom_clk_en), .dom_rst(dom_rst), .dom_timer_load(dom_timer_load),
      .dom_timer_run(dom_timer_run), .dom_footer(dom_footer), .dom_iso_rel(dom_iso_rel));

   always #2 clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit cmp_en = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model: scheduled word writes ----------------
   int  m_tim [ND];
   int  m_ctl [ND];
   int  m_sw  [ND];
   bit  m_on  [ND];
   bit  m_busy = 0, m_done = 0, m_err = 0, m_up = 0;
   int  m_dom = 0, m_end = 0, cyc = 0;
   int  q_cyc [$];
   int  q_dom [$];
   int  q_word[$];
   int  q_val [$];

   initial for (int d = 0; d < ND; d++) begin m_tim[d] = 0; m_ctl[d] = 1; m_sw[d] = 0; m_on[d] = 0; end

   task automatic sched(input int k, input int d, input int w, input int v);
      q_cyc.push_back(cyc + 1 + k * S); q_dom.push_back(d); q_word.push_back(w); q_val.push_back(v);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int d = 0; d < ND; d++) begin m_tim[d] = 0; m_ctl[d] = 1; m_sw[d] = 0; m_on[d] = 0; end
         m_busy = 0; m_done = 0; m_err = 0; cyc = 0;
         q_cyc.delete(); q_dom.delete(); q_word.delete(); q_val.delete();
      end else begin
         bit was;
         cyc++;
         was = m_busy;
         m_done = 0;
         while (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
            case (q_word[0])
               0: m_tim[q_dom[0]] = q_val[0];
               1: m_ctl[q_dom[0]] = q_val[0];
               default: m_sw[q_dom[0]] = q_val[0];
            endcase
            void'(q_cyc.pop_front()); void'(q_dom.pop_front());
            void'(q_word.pop_front()); void'(q_val.pop_front());
         end
         if (was && cyc == m_end) begin m_busy = 0; m_done = 1; m_on[m_dom] = m_up; end
         if (req_valid) begin
            if (was) m_err = 1;
            else if (int'(req_dom) >= ND) m_err = 1;
            else if (m_on[req_dom] == req_on) m_done = 1;
            else begin
               m_busy = 1; m_dom = int'(req_dom); m_up = req_on;
               if (req_on) begin
                  sched(0, m_dom, 1, 3);  sched(1, m_dom, 0, GSET);
                  sched(2, m_dom, 2, 1);  sched(3, m_dom, 2, 3);
                  sched(4, m_dom, 2, 7);  sched(5, m_dom, 2, 15);
                  sched(6, m_dom, 0, GRUN); sched(7, m_dom, 1, 2);
                  sched(8, m_dom, 2, 31);
                  m_end = cyc + 9 * S;
               end else begin
                  sched(0, m_dom, 2, 15); sched(1, m_dom, 0, 0);
                  sched(2, m_dom, 1, 3);  sched(3, m_dom, 1, 1);
                  sched(4, m_dom, 2, 0);
                  m_end = cyc + 5 * S;
               end
            end
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_en) begin
         int ad, ao, exp_rd;
         chk("R6 done", int'(done), int'(m_done));
         chk("R5 busy", int'(busy), int'(m_busy));
         chk("R7 err", int'(err), int'(m_err));
         for (int d = 0; d < ND; d++) begin
            chk("R3 R4 R10 clk_en", int'(dom_clk_en[d]), (m_ctl[d] >> 1) & 1);
            chk("R3 R4 R10 rst", int'(dom_rst[d]), m_ctl[d] & 1);
            chk("R3 R4 R10 timer_load", int'(dom_timer_load[d]), (m_tim[d] >> 1) & 1);
            chk("R3 R4 R10 timer_run", int'(dom_timer_run[d]), m_tim[d] & 1);
            chk("R3 R4 R10 footer", int'(dom_footer[d*NF +: NF]), m_sw[d] & 15);
            chk("R3 R4 R10 iso", int'(dom_iso_rel[d]), (m_sw[d] >> 4) & 1);
         end
         ad = int'(rd_addr) / 12; ao = int'(rd_addr) % 12;
         exp_rd = 0;
         if (ad < ND) begin
            if (ao == 0) exp_rd = m_tim[ad];
            else if (ao == 4) exp_rd = m_ctl[ad];
            else if (ao == 8) exp_rd = m_sw[ad];
         end
         chk("R2 rd_data", int'(rd_data), exp_rd);
      end
   end

   // ---------------- watchdog ----------------
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 20000) begin
         checks++; failures++;
         $display("FAIL R5 watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step1();
      @(negedge clk); #1;
   endtask

   task automatic send(input int d, input bit on);
      step1(); req_valid = 1'b1; req_dom = 2'(d); req_on = on;
      step1(); req_valid = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      step1(); rd_addr = 6'(a); #0.5; v = int'(rd_data);
   endtask

   task automatic do_reset();
      step1(); rst_n = 1'b0;
      repeat (3) step1();
      rst_n = 1'b1;
   endtask

   task automatic run_seq(input int d, input bit on, input int nsteps);
      int n;
      send(d, on);
      n = 0;
      while (busy === 1'b1 && n < 1000) begin n++; step1(); end
      chk("R5 busy length", n, nsteps * S);
      chk("R6 done at busy fall", int'(done), 1);
      step1();
      chk("R6 done one cycle", int'(done), 0);
   endtask

   initial begin
      int v;
      do_reset();
      cmp_en = 1;
      step1();
      // R1: reset state
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 err", int'(err), 0);
      chk("R1 clk_en", int'(dom_clk_en), 0);
      chk("R1 rst", int'(dom_rst), 7);
      chk("R1 footer", int'(dom_footer), 0);
      rd(28, v); chk("R1 R2 ctrl word dom2", v, 1);
      rd(12, v); chk("R1 R2 timer word dom1", v, 0);

      // R3 / R5: power up domain 0
      run_seq(0, 1'b1, 9);
      rd(0, v); chk("R2 R3 timer word", v, GRUN);
      rd(4, v); chk("R2 R3 ctrl word", v, 2);
      rd(8, v); chk("R2 R3 switch word", v, 31);

      // R8: already on
      send(0, 1'b1);
      chk("R8 done", int'(done), 1);
      chk("R8 busy", int'(busy), 0);
      step1();
      chk("R8 done clears", int'(done), 0);
      rd(8, v); chk("R8 switch word unchanged", v, 31);

      // R7 / R10: request during another domain's sequence
      send(1, 1'b1);
      step1();
      chk("R3 step0 clock on", int'(dom_clk_en[1]), 1);
      chk("R11 reset held with clock on", int'(dom_rst[1]), 1);
      repeat (5) step1();
      send(2, 1'b1);
      chk("R7 err set", int'(err), 1);
      while (busy === 1'b1) step1();
      step1();
      rd(28, v); chk("R7 ignored domain ctrl", v, 1);
      rd(32, v); chk("R7 ignored domain switch", v, 0);
      rd(8, v);  chk("R10 other domain kept", v, 31);
      rd(20, v); chk("R3 dom1 switch word", v, 31);
      chk("R7 err sticky", int'(err), 1);

      // R4: power down domain 0
      run_seq(0, 1'b0, 5);
      rd(0, v); chk("R4 timer word", v, 0);
      rd(4, v); chk("R4 ctrl word", v, 1);
      rd(8, v); chk("R4 switch word", v, 0);

      // R2: unused addresses
      rd(2, v);  chk("R2 unaligned", v, 0);
      rd(40, v); chk("R2 beyond domains", v, 0);
      rd(12, v); chk("R2 dom1 timer", v, GRUN);

      // R9: out-of-range index after a clean reset
      do_reset();
      step1();
      chk("R1 err after reset", int'(err), 0);
      send(3, 1'b1);
      chk("R9 err", int'(err), 1);
      chk("R9 busy", int'(busy), 0);
      chk("R9 done", int'(done), 0);
      chk("R9 clk_en", int'(dom_clk_en), 0);

      // R8: off request for an off domain
      send(2, 1'b0);
      chk("R8 off done", int'(done), 1);
      rd(28, v); chk("R8 off ctrl word", v, 1);

      // power domain 2 up and down
      run_seq(2, 1'b1, 9);
      rd(32, v); chk("R3 dom2 switch", v, 31);
      run_seq(2, 1'b0, 5);
      rd(28, v); chk("R4 dom2 ctrl", v, 1);

      repeat (3) step1();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule